// File: doc/BRIEF.md
# Double-Buffered Modulation Sequencer

This block plays an 8-bit amplitude waveform out of one of two segment memories, one sample at a time. A free-running tick counter paces it: the sample index steps once every `div + 1` clock cycles. The waveform runs for a programmed number of laps and then freezes on its final sample, or it loops without end. Two segments are kept so that software can fill one while the other plays. A pending request to change to the other segment is granted only when the selected transition condition is met: index wrap, a system-time deadline, a chosen GPIO line, an external trigger pulse, or at once.

The memories sit outside the block. Their read port is asynchronous. Each 16-bit word carries two samples. The block sends out a word address and a segment select, and it registers the chosen byte, so `sample_o` follows the index by one clock. Each segment has its own divider, cycle-length and repeat configuration. The top level selects the set that belongs to the active segment.

The control state machine has two states. **ST_PLAY** steps through the waveform. **ST_HOLD** keeps the last sample once the finite laps are used up. Its transitions are named as follows:
- *lap_exhausted* goes from ST_PLAY to ST_HOLD. It fires on a tick at the last index when the lap count equals the repeat value.
- *switch_play* goes from ST_PLAY to ST_PLAY. It is a granted segment change that restarts the index at 0.
- *switch_hold* goes from ST_HOLD to ST_PLAY. It is a granted segment change out of the frozen state.

Top module: `modseq_player`

## Requirements
- R1: During and right after reset, `seg_o`=0, `done_o`=0, `mem_addr_o`=0 and `sample_o`=0.
- R2: Sample index i reads word i>>1. An even index takes bits [7:0] of that word and an odd index takes bits [15:8]. `sample_o` shows the byte for the index held before the previous rising edge.
- R3: With divider value d for the active segment, the index moves once every d+1 cycles. d=0 moves it every cycle.
- R4: A cycle has `cyc`+1 samples. After index `cyc`, the index returns to 0.
- R5: A repeat value v other than 0xFFFFFFFF plays v+1 laps. After that the index stays on `cyc`, `sample_o` stays on the last sample and `done_o` is 1.
- R6: A repeat value of 0xFFFFFFFF loops without end and never sets `done_o`.
- R7: Mode 0 (sync-index) grants a pending change only on a tick at index `cyc`. In ST_HOLD it grants on the next tick.
- R8: Mode 1 (system time) grants on the first tick where `sys_time_i` >= `xfer_val_i`. Both are unsigned 64-bit nanosecond counts.
- R9: Mode 2 (GPIO) grants on a tick where `gpio_i[xfer_val_i[1:0]]` is 1. The other GPIO lines have no effect.
- R10: Mode 3 (external) grants on the first tick at or after an `ext_trig_i` pulse seen while the change is pending. A one-cycle pulse between ticks is not lost.
- R11: Mode 4 (immediate) grants on the next tick.
- R12: A change is pending while `req_seg_i` differs from `seg_o`. When it is granted, `seg_o` takes the requested value, the index and lap count restart at 0, `done_o` clears, and the new segment's divider, cycle and repeat settings apply.
- R13: Mode codes 5 to 7 never grant a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div0_i | input | 32 | Tick divider, segment 0 |
| div1_i | input | 32 | Tick divider, segment 1 |
| cyc0_i | input | 15 | Last sample index, segment 0 |
| cyc1_i | input | 15 | Last sample index, segment 1 |
| rep0_i | input | 32 | Repeat value, segment 0 |
| rep1_i | input | 32 | Repeat value, segment 1 |
| req_seg_i | input | 1 | Requested segment |
| mode_i | input | 3 | Transition mode code |
| xfer_val_i | input | 64 | Transition value (deadline or GPIO index) |
| gpio_i | input | 4 | GPIO lines |
| ext_trig_i | input | 1 | External trigger |
| sys_time_i | input | 64 | System time in ns |
| mem_addr_o | output | 14 | Word address to the segment memory |
| mem_seg_o | output | 1 | Segment memory select |
| mem_rdata_i | input | 16 | Word read from the memory (asynchronous) |
| sample_o | output | 8 | Current sample |
| seg_o | output | 1 | Active segment |
| done_o | output | 1 | Finite laps exhausted |

## Verification
The hardest case to reach is a grant that falls together with the end of a lap. Examples are a sync-index switch on the exact tick where the lap would otherwise wrap or exhaust, or an external pulse that lands between ticks under a divider greater than zero. Directed phases set small dividers and short cycles so that these edges come within a few dozen cycles. A seeded random phase then re-draws dividers, cycles, repeats, modes and GPIO/trigger activity every 20 cycles. A cycle-level model in the bench, built from the requirements, is compared on every cycle.

// File: rtl/modseq_pkg.sv
package modseq_pkg;

    // Transition mode codes (3-bit field); 5..7 are reserved.
    typedef enum logic [2:0] {
        XF_SYNC_IDX  = 3'd0,
        XF_SYS_TIME  = 3'd1,
        XF_GPIO      = 3'd2,
        XF_EXT       = 3'd3,
        XF_IMMEDIATE = 3'd4
    } xfer_mode_e;

    typedef enum logic {
        ST_PLAY = 1'b0,
        ST_HOLD = 1'b1
    } play_state_e;

endpackage

// File: rtl/modseq_tick.sv
module modseq_tick #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // A tick fires when the count reaches the divider; >= keeps a shrinking
    // divider from forcing a full wrap of the counter.
    assign tick_o = (cnt_q >= div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/modseq_xfer_gate.sv
module modseq_xfer_gate
    import modseq_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int GPIO_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending_i,
    input  logic              tick_i,
    input  logic              at_last_i,
    input  logic              holding_i,
    input  logic [2:0]        mode_i,
    input  logic [TIME_W-1:0] val_i,
    input  logic [GPIO_N-1:0] gpio_i,
    input  logic              ext_i,
    input  logic [TIME_W-1:0] sys_time_i,
    output logic              go_o
);

    localparam int GSEL_W = $clog2(GPIO_N);

    logic ext_seen_q;
    logic cond;

    always_comb begin
        unique case (mode_i)
            XF_SYNC_IDX:  cond = at_last_i | holding_i;
            XF_SYS_TIME:  cond = (sys_time_i >= val_i);
            XF_GPIO:      cond = gpio_i[val_i[GSEL_W-1:0]];
            XF_EXT:       cond = ext_seen_q | ext_i;
            XF_IMMEDIATE: cond = 1'b1;
            default:      cond = 1'b0;
        endcase
    end

    assign go_o = pending_i & tick_i & cond;

    // Trigger pulse is remembered while a change is pending so that a pulse
    // arriving between ticks still causes the switch on the next tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_seen_q <= 1'b0;
        end else begin
            ext_seen_q <= pending_i & ~go_o & (ext_seen_q | ext_i);
        end
    end

endmodule

// File: rtl/modseq_fsm.sv
module modseq_fsm
    import modseq_pkg::*;
#(
    parameter int IDX_W = 15,
    parameter int REP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             go_i,
    input  logic             req_seg_i,
    input  logic [IDX_W-1:0] cyc_i,
    input  logic [REP_W-1:0] rep_i,
    output logic             seg_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             at_last_o,
    output logic             holding_o
);

    play_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [REP_W-1:0] laps_q;
    logic             seg_q;
    logic             finite;
    logic             exhausted;
    logic             lap_end;

    assign finite    = (rep_i != {REP_W{1'b1}});
    assign exhausted = finite && (laps_q == rep_i);
    assign lap_end   = (idx_q == cyc_i);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PLAY: begin
                if (go_i) begin
                    state_d = ST_PLAY;                       // switch_play
                end else if (tick_i && lap_end && exhausted) begin
                    state_d = ST_HOLD;                       // lap_exhausted
                end
            end
            ST_HOLD: begin
                if (go_i) begin
                    state_d = ST_PLAY;                       // switch_hold
                end
            end
            default: state_d = ST_PLAY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PLAY;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers driven by the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q  <= 1'b0;
            idx_q  <= '0;
            laps_q <= '0;
        end else if (go_i) begin
            seg_q  <= req_seg_i;
            idx_q  <= '0;
            laps_q <= '0;
        end else if (tick_i && state_q == ST_PLAY) begin
            if (!lap_end) begin
                idx_q <= idx_q + 1'b1;
            end else if (!exhausted) begin
                idx_q <= '0;
                if (finite) begin
                    laps_q <= laps_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        seg_o     = seg_q;
        idx_o     = idx_q;
        at_last_o = lap_end && (state_q == ST_PLAY);
        holding_o = (state_q == ST_HOLD);
    end

endmodule

// File: rtl/modseq_unpack.sv
module modseq_unpack #(
    parameter int WORD_W   = 16,
    parameter int SAMPLE_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [WORD_W-1:0]                 word_i,
    input  logic [$clog2(WORD_W/SAMPLE_W)-1:0] lane_sel_i,
    output logic [SAMPLE_W-1:0]               sample_o
);

    localparam int LANES = WORD_W / SAMPLE_W;

    logic [SAMPLE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[g*SAMPLE_W +: SAMPLE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_o <= '0;
        end else begin
            sample_o <= lane[lane_sel_i];
        end
    end

endmodule

// File: rtl/modseq_player.sv
module modseq_player #(
    parameter int IDX_W    = 15,
    parameter int DIV_W    = 32,
    parameter int REP_W    = 32,
    parameter int TIME_W   = 64,
    parameter int GPIO_N   = 4,
    parameter int WORD_W   = 16,
    parameter int SAMPLE_W = 8,
    localparam int LANE_W  = $clog2(WORD_W / SAMPLE_W),
    localparam int ADDR_W  = IDX_W - LANE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    div0_i,
    input  logic [DIV_W-1:0]    div1_i,
    input  logic [IDX_W-1:0]    cyc0_i,
    input  logic [IDX_W-1:0]    cyc1_i,
    input  logic [REP_W-1:0]    rep0_i,
    input  logic [REP_W-1:0]    rep1_i,
    input  logic                req_seg_i,
    input  logic [2:0]          mode_i,
    input  logic [TIME_W-1:0]   xfer_val_i,
    input  logic [GPIO_N-1:0]   gpio_i,
    input  logic                ext_trig_i,
    input  logic [TIME_W-1:0]   sys_time_i,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic                mem_seg_o,
    input  logic [WORD_W-1:0]   mem_rdata_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                seg_o,
    output logic                done_o
);

    logic [DIV_W-1:0] div_sel;
    logic [IDX_W-1:0] cyc_sel;
    logic [REP_W-1:0] rep_sel;
    logic             seg;
    logic [IDX_W-1:0] idx;
    logic             tick;
    logic             go;
    logic             at_last;
    logic             holding;

    // Per-segment configuration selected by the active segment
    assign div_sel = seg ? div1_i : div0_i;
    assign cyc_sel = seg ? cyc1_i : cyc0_i;
    assign rep_sel = seg ? rep1_i : rep0_i;

    modseq_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_sel),
        .tick_o (tick)
    );

    modseq_xfer_gate #(.TIME_W(TIME_W), .GPIO_N(GPIO_N)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending_i  (req_seg_i != seg),
        .tick_i     (tick),
        .at_last_i  (at_last),
        .holding_i  (holding),
        .mode_i     (mode_i),
        .val_i      (xfer_val_i),
        .gpio_i     (gpio_i),
        .ext_i      (ext_trig_i),
        .sys_time_i (sys_time_i),
        .go_o       (go)
    );

    modseq_fsm #(.IDX_W(IDX_W), .REP_W(REP_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .go_i      (go),
        .req_seg_i (req_seg_i),
        .cyc_i     (cyc_sel),
        .rep_i     (rep_sel),
        .seg_o     (seg),
        .idx_o     (idx),
        .at_last_o (at_last),
        .holding_o (holding)
    );

    modseq_unpack #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_i     (mem_rdata_i),
        .lane_sel_i (idx[LANE_W-1:0]),
        .sample_o   (sample_o)
    );

    assign mem_addr_o = idx[IDX_W-1:LANE_W];
    assign mem_seg_o  = seg;
    assign seg_o      = seg;
    assign done_o     = holding;

endmodule

// File: rtl/modseq_player_chk.sv
module modseq_player_chk #(
    parameter int ADDR_W = 14,
    parameter int REP_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seg_o,
    input logic              done_o,
    input logic              req_seg_i,
    input logic [2:0]        mode_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [REP_W-1:0]  rep0_i,
    input logic [REP_W-1:0]  rep1_i
);

    logic [REP_W-1:0] rep_act;
    assign rep_act = seg_o ? rep1_i : rep0_i;

    AST_HOLD_FREEZES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o)) |-> $stable(mem_addr_o)) else $error("hold moved"); // R5

    AST_FOREVER_NEVER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(rep_act) != {REP_W{1'b1}})) else $error("infinite done"); // R6

    AST_SEG_TAKES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_o != $past(seg_o)) |-> (seg_o == $past(req_seg_i))) else $error("bad seg"); // R12

    AST_SWITCH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_o != $past(seg_o)) |-> (mem_addr_o == '0 && !done_o)) else $error("no restart"); // R12

    AST_RESERVED_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) > 3'd4) |-> (seg_o == $past(seg_o))) else $error("reserved switched"); // R13

endmodule

bind modseq_player modseq_player_chk #(.ADDR_W(ADDR_W), .REP_W(REP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seg_o      (seg_o),
    .done_o     (done_o),
    .req_seg_i  (req_seg_i),
    .mode_i     (mode_i),
    .mem_addr_o (mem_addr_o),
    .rep0_i     (rep0_i),
    .rep1_i     (rep1_i)
);

// File: tb/test_modseq_player.sv
module test_modseq_player;

    localparam logic [31:0] FOREVER = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] div0 = 0, div1 = 0, rep0 = FOREVER, rep1 = FOREVER;
    logic [14:0] cyc0 = 15'd3, cyc1 = 15'd3;
    logic        req_seg = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [63:0] xval = 64'd0;
    logic [3:0]  gpio = 4'd0;
    logic        ext = 1'b0;
    logic [63:0] sys_time = 64'd1000;
    logic [13:0] mem_addr;
    logic        mem_seg;
    logic [15:0] mem_rdata;
    logic [7:0]  sample;
    logic        seg, done;

    logic [15:0] mem0 [64];
    logic [15:0] mem1 [64];

    int    n_run = 0, n_fail = 0;
    string cur_tag = "R1";
    bit    cmp_on = 1'b0;
    bit    ext_rand = 1'b0;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem_seg ? mem1[mem_addr[5:0]] : mem0[mem_addr[5:0]];

    modseq_player i_modseq_player (
        .clk(clk), .rst_n(rst_n),
        .div0_i(div0), .div1_i(div1), .cyc0_i(cyc0), .cyc1_i(cyc1),
        .rep0_i(rep0), .rep1_i(rep1), .req_seg_i(req_seg), .mode_i(mode),
        .xfer_val_i(xval), .gpio_i(gpio), .ext_trig_i(ext), .sys_time_i(sys_time),
        .mem_addr_o(mem_addr), .mem_seg_o(mem_seg), .mem_rdata_i(mem_rdata),
        .sample_o(sample), .seg_o(seg), .done_o(done)
    );

    always @(negedge clk) sys_time <= sys_time + 64'd1;

    // Reference model built from the requirements
    logic        m_seg, m_hold, m_ext;
    logic [14:0] m_idx, cc;
    logic [31:0] m_laps, m_cnt, cd, cr;
    logic [7:0]  m_sample;
    logic [15:0] mw;
    logic        tk, lst, pnd, cnd, mgo;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_seg = 0; m_hold = 0; m_ext = 0; m_idx = 0; m_laps = 0; m_cnt = 0; m_sample = 0;
        end else begin
            mw = m_seg ? mem1[m_idx[6:1]] : mem0[m_idx[6:1]];
            m_sample = m_idx[0] ? mw[15:8] : mw[7:0];          // R2
            cd = m_seg ? div1 : div0;
            cc = m_seg ? cyc1 : cyc0;
            cr = m_seg ? rep1 : rep0;
            tk  = (m_cnt >= cd);                                // R3
            lst = (m_idx == cc);
            pnd = (req_seg != m_seg);
            case (mode)
                3'd0: cnd = m_hold | lst;                       // R7
                3'd1: cnd = (sys_time >= xval);                 // R8
                3'd2: cnd = gpio[xval[1:0]];                    // R9
                3'd3: cnd = m_ext | ext;                        // R10
                3'd4: cnd = 1'b1;                               // R11
                default: cnd = 1'b0;                            // R13
            endcase
            mgo = pnd & tk & cnd;
            m_ext = pnd & ~mgo & (m_ext | ext);
            m_cnt = tk ? 32'd0 : m_cnt + 32'd1;
            if (mgo) begin                                      // R12
                m_seg = req_seg; m_idx = 0; m_laps = 0; m_hold = 0;
            end else if (tk && !m_hold) begin
                if (!lst) m_idx = m_idx + 15'd1;
                else if (cr != FOREVER && m_laps == cr) m_hold = 1;   // R5
                else begin
                    m_idx = 0;                                  // R4
                    if (cr != FOREVER) m_laps = m_laps + 32'd1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check({sample, mem_addr, seg, done} == {m_sample, m_idx[14:1], m_seg, m_hold},
                  cur_tag, {sample, mem_addr, seg, done}, {m_sample, m_idx[14:1], m_seg, m_hold});
        end
    end

    task automatic run(input int n, input string tag);
        cur_tag = tag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ext = ext_rand ? ($urandom % 8 == 0) : 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            mem0[i] = 16'($urandom);
            mem1[i] = 16'($urandom);
        end
        mem0[0] = 16'h1234; mem0[1] = 16'h5678;
        repeat (4) @(negedge clk);
        check(sample == 8'h00 && seg == 1'b0 && done == 1'b0 && mem_addr == 14'd0,
              "R1 reset", {sample, seg, done, mem_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(seg == 1'b0 && done == 1'b0, "R1 after reset", {seg, done}, 0);
        cmp_on = 1'b1;
        cyc0 = 15'd2;
        run(12, "R2 R4 packing and wrap");
        // index 0 then 1: low byte 0x34 then high byte 0x12 observed in order
        div0 = 32'd3;
        run(30, "R3 divider");
        rep0 = 32'd1;
        run(60, "R5 finite laps");
        check(done == 1'b1, "R5 done set", done, 1);
        check(sample == ((mem0[1] >> 0) & 8'hFF), "R5 last sample held", sample, mem0[1][7:0]);
        div1 = 32'd1; cyc1 = 15'd4; rep1 = FOREVER;
        mode = 3'd0; req_seg = 1'b1;
        run(6, "R7 R12 switch out of hold");
        check(seg == 1'b1 && done == 1'b0, "R12 switch from hold", {seg, done}, 2);
        rep0 = FOREVER;
        req_seg = 1'b0;
        run(40, "R7 sync-index wrap");
        check(seg == 1'b0, "R7 sync switch", seg, 0);
        run(100, "R6 infinite");
        check(done == 1'b0, "R6 no done", done, 0);
        mode = 3'd4; req_seg = 1'b1;
        run(6, "R11 immediate");
        check(seg == 1'b1, "R11 immediate switch", seg, 1);
        mode = 3'd1; xval = sys_time + 64'd30; req_seg = 1'b0;
        run(20, "R8 before deadline");
        check(seg == 1'b1, "R8 no early switch", seg, 1);
        run(20, "R8 after deadline");
        check(seg == 1'b0, "R8 switch at deadline", seg, 0);
        mode = 3'd2; xval = 64'd2; req_seg = 1'b1; gpio = 4'b1011;
        run(20, "R9 other lines");
        check(seg == 1'b0, "R9 unselected gpio ignored", seg, 0);
        gpio = 4'b0100;
        run(10, "R9 selected line");
        check(seg == 1'b1, "R9 gpio switch", seg, 1);
        gpio = 4'b0000; mode = 3'd3; req_seg = 1'b0; div1 = 32'd5;
        run(10, "R10 no trigger");
        check(seg == 1'b1, "R10 waits for trigger", seg, 1);
        @(negedge clk); ext = 1'b1;
        @(negedge clk); ext = 1'b0;
        run(8, "R10 latched pulse");
        check(seg == 1'b0, "R10 trigger switch", seg, 0);
        mode = 3'd6; req_seg = 1'b1;
        run(30, "R13 reserved");
        check(seg == 1'b0, "R13 reserved no switch", seg, 0);
        ext_rand = 1'b1;
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            div0 = $urandom % 4; div1 = $urandom % 4;
            cyc0 = 15'($urandom % 40); cyc1 = 15'($urandom % 40);
            rep0 = ($urandom % 2) ? FOREVER : ($urandom % 3);
            rep1 = ($urandom % 2) ? FOREVER : ($urandom % 3);
            mode = 3'($urandom % 8); req_seg = 1'($urandom);
            xval = ($urandom % 2) ? sys_time + ($urandom % 30) : 64'($urandom % 4);
            gpio = 4'($urandom);
            run(19, "R12 random mix");
        end
        ext_rand = 1'b0;
        cmp_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule